// File: doc/BRIEF.md
# Conditional Branch-to-Link Resolver

This block settles the outcome of a conditional branch whose destination is held in a link register. With each instruction it receives a 5-bit option code, a 5-bit index into a 32-bit condition word, a link request flag, the condition word itself and the address of the instruction that follows the branch. It holds a 32-bit loop counter and a 32-bit link register of its own. From these it decides whether the branch is taken, forms the target address, and flags option codes whose reserved bits are set.

The option code selects any combination of four things: a counter decrement, a test of the decremented counter for zero or non-zero, a test of the chosen condition bit for true or false, or neither test. A mode input picks between strict checking of reserved bits and a relaxed mode that accepts any value in them. Results are registered and appear one clock after the input strobe. The counter and link values are available on output ports so that the surrounding logic can read the architectural state.

Top module: `brl_resolver`

## Requirements
- R1: The target output equals bits 31..2 of the link register with two zero bits below them, taken from the link value held before the same instruction's link update.
- R2: On a valid-form instruction with `link_req`=1 the link register becomes `next_pc`; with `link_req`=0 it keeps its value.
- R3: For codes 0000y and 0001y (leftmost character is `opt[4]`) the counter is decremented and the branch is taken only when the condition bit is 0; 0000y also needs the new counter non-zero, 0001y needs it zero.
- R4: For codes 0100y and 0101y the counter is decremented and the branch is taken only when the condition bit is 1; 0100y needs the new counter non-zero, 0101y needs it zero.
- R5: Code 001zy is taken when the condition bit is 0 and 011zy when it is 1; neither changes the counter.
- R6: Codes 1z00y and 1z01y decrement the counter and are taken when the new counter is non-zero (1z00y) or zero (1z01y), whatever the condition bit.
- R7: Codes 1z1zz are always taken and leave the counter unchanged.
- R8: With `strict`=1 a 1 in any z position (`opt[1]` for 001zy/011zy; `opt[3]` for 1z0xy; `opt[3]`, `opt[1]`, `opt[0]` for 1z1zz) raises `bad_form`; with `strict`=0 `bad_form` stays 0.
- R9: The y bit (`opt[0]`) never changes taken, counter or link results.
- R10: `cr_idx`=k selects `cr_word[31-k]`, so index 0 is the most significant bit.
- R11: When `bad_form` is 1 the taken flag is 0 and neither counter nor link changes.
- R12: `res_valid` is 1 exactly one cycle after `in_valid`, and 0 otherwise.
- R13: A requested decrement is committed whether or not the branch is taken and wraps from 0 to 32'hFFFF_FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction strobe |
| opt | input | 5 | Branch option code, `opt[4]` leftmost |
| cr_idx | input | 5 | Condition bit index, 0 = MSB |
| link_req | input | 1 | Write next address to link register |
| cr_word | input | 32 | Condition word |
| next_pc | input | 32 | Address of following instruction |
| strict | input | 1 | 1 = reserved bits must be 0 |
| res_valid | output | 1 | Result strobe |
| res_taken | output | 1 | Branch taken |
| res_target | output | 32 | Target address |
| bad_form | output | 1 | Reserved-bit violation |
| ctr_value | output | 32 | Current counter |
| link_value | output | 32 | Current link register |

## Verification
A wrong counter value shows first as a wrong `ctr_value` one cycle after the instruction that produced it, and later as a flipped taken flag on the first zero-test code that follows. A corrupted link register appears on `link_value` at once and in `res_target` on the very next branch. A faulty reserved-bit decode shows on `bad_form` in the result cycle and, through suppressed updates, on the state ports in the same cycle.

// File: rtl/brl_pkg.sv
package brl_pkg;
  localparam int OPT_W = 5;

  typedef struct packed {
    logic dec;        // counter decrement requested
    logic want_zero;  // counter test expects zero
    logic use_cond;   // condition bit participates
    logic sense;      // required condition bit value
    logic z_bad;      // reserved bit violation (strict only)
  } opt_dec_t;
endpackage

// File: rtl/brl_opt_decode.sv
module brl_opt_decode
  import brl_pkg::*;
(
  input  logic [OPT_W-1:0] opt,
  input  logic             strict,
  output opt_dec_t         d
);
  logic z_raw;

  always_comb begin
    if (opt[4]) begin
      if (opt[2]) z_raw = opt[3] | opt[1] | opt[0];
      else        z_raw = opt[3];
    end else begin
      if (opt[2]) z_raw = opt[1];
      else        z_raw = 1'b0;
    end
  end

  always_comb begin
    d.dec       = ~opt[2];
    d.want_zero = opt[1];
    d.use_cond  = ~opt[4];
    d.sense     = opt[3];
    d.z_bad     = strict & z_raw;
  end

  // R8 relaxed mode never reports a violation
  always_comb begin
    if (!strict) a_r8_relaxed: assert (d.z_bad == 1'b0);
  end
endmodule

// File: rtl/brl_cond_select.sv
module brl_cond_select #(
  parameter int CR_W  = 32,
  parameter int IDX_W = $clog2(CR_W)
) (
  input  logic [CR_W-1:0]  cr_word,
  input  logic [IDX_W-1:0] idx,
  output logic             bit_o
);
  localparam int TOP = CR_W - 1;
  always_comb bit_o = cr_word[TOP - int'(idx)];
endmodule

// File: rtl/brl_state.sv
module brl_state #(
  parameter int          W        = 32,
  parameter logic [W-1:0] CTR_INIT = '0,
  parameter logic [W-1:0] LNK_INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ctr_we,
  input  logic         lnk_we,
  input  logic [W-1:0] lnk_d,
  output logic [W-1:0] ctr_q,
  output logic [W-1:0] ctr_dec,
  output logic [W-1:0] lnk_q
);
  always_comb ctr_dec = ctr_q - W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr_q <= CTR_INIT;
      lnk_q <= LNK_INIT;
    end else begin
      if (ctr_we) ctr_q <= ctr_dec;
      if (lnk_we) lnk_q <= lnk_d;
    end
  end

  // R13 counter changes only by one step downward
  a_r13_step: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctr_q) |-> (ctr_q == $past(ctr_q) - W'(1)));
endmodule

// File: rtl/brl_resolver.sv
module brl_resolver
  import brl_pkg::*;
#(
  parameter int           W        = 32,
  parameter int           CR_W     = 32,
  parameter logic [W-1:0] CTR_INIT = 32'd3,
  parameter logic [W-1:0] LNK_INIT = 32'h0000_1000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [OPT_W-1:0]         opt,
  input  logic [$clog2(CR_W)-1:0]  cr_idx,
  input  logic                     link_req,
  input  logic [CR_W-1:0]          cr_word,
  input  logic [W-1:0]             next_pc,
  input  logic                     strict,
  output logic                     res_valid,
  output logic                     res_taken,
  output logic [W-1:0]             res_target,
  output logic                     bad_form,
  output logic [W-1:0]             ctr_value,
  output logic [W-1:0]             link_value
);
  localparam int ALIGN = 2;

  opt_dec_t   d;
  logic       cbit;
  logic       ok_form;
  logic       cond_ok;
  logic       ctr_ok;
  logic       taken_c;
  logic       ctr_we;
  logic       lnk_we;
  logic [W-1:0] ctr_q, ctr_dec, lnk_q;

  brl_opt_decode u_dec (.opt(opt), .strict(strict), .d(d));

  brl_cond_select #(.CR_W(CR_W)) u_sel (
    .cr_word(cr_word), .idx(cr_idx), .bit_o(cbit));

  brl_state #(.W(W), .CTR_INIT(CTR_INIT), .LNK_INIT(LNK_INIT)) u_st (
    .clk(clk), .rst(rst), .ctr_we(ctr_we), .lnk_we(lnk_we),
    .lnk_d(next_pc), .ctr_q(ctr_q), .ctr_dec(ctr_dec), .lnk_q(lnk_q));

  always_comb begin
    ok_form = ~d.z_bad;
    cond_ok = ~d.use_cond | (cbit == d.sense);
    ctr_ok  = ~d.dec | ((ctr_dec == '0) == d.want_zero);
    taken_c = ok_form & cond_ok & ctr_ok;
    ctr_we  = in_valid & ok_form & d.dec;
    lnk_we  = in_valid & ok_form & link_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_taken  <= 1'b0;
      res_target <= '0;
      bad_form   <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        res_taken  <= taken_c;
        res_target <= {lnk_q[W-1:ALIGN], {ALIGN{1'b0}}};
        bad_form   <= d.z_bad;
      end
    end
  end

  always_comb begin
    ctr_value  = ctr_q;
    link_value = lnk_q;
  end

  // R12 one-cycle result strobe
  a_r12_strobe: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);
  a_r12_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid);
  // R11 invalid form never taken
  a_r11_no_take: assert property (@(posedge clk) disable iff (rst)
    (res_valid && bad_form) |-> !res_taken);
  // R1 target is word aligned
  a_r1_aligned: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_target[ALIGN-1:0] == '0));
  // R2 link holds without a link request
  a_r2_link_hold: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || !link_req) |=> (link_value == $past(link_value)));
  // R5 R7 codes without decrement leave the counter alone
  a_r5_ctr_hold: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opt[2]) |=> $stable(ctr_value));
endmodule

// File: tb/brl_resolver_tb.sv
module brl_resolver_tb_top;
  localparam logic [31:0] CI = 32'd3;
  localparam logic [31:0] LI = 32'h0000_1000;

  logic clk = 0, rst = 1, in_valid = 0, link_req = 0, strict = 1;
  logic [4:0] opt = 0, cr_idx = 0;
  logic [31:0] cr_word = 0, next_pc = 0;
  logic res_valid, res_taken, bad_form;
  logic [31:0] res_target, ctr_value, link_value;

  int total = 0, bad = 0;
  logic [31:0] m_ctr, m_lnk;

  always #5 clk = ~clk;

  brl_resolver #(.CTR_INIT(CI), .LNK_INIT(LI)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opt(opt), .cr_idx(cr_idx),
    .link_req(link_req), .cr_word(cr_word), .next_pc(next_pc), .strict(strict),
    .res_valid(res_valid), .res_taken(res_taken), .res_target(res_target),
    .bad_form(bad_form), .ctr_value(ctr_value), .link_value(link_value));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [4:0] o);
    if (o[4] && o[2]) return "R7";
    if (o[4])         return "R6";
    if (o[2])         return "R5";
    if (o[3])         return "R4";
    return "R3";
  endfunction

  function automatic logic zbits(input logic [4:0] o);
    if (o[4]) return o[2] ? (o[3] | o[1] | o[0]) : o[3];
    return o[2] ? o[1] : 1'b0;
  endfunction

  task automatic do_reset();
    rst = 1; in_valid = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    m_ctr = CI; m_lnk = LI;
  endtask

  task automatic op(input logic [4:0] o, input logic [4:0] ix, input logic lk,
                    input logic [31:0] cr, input logic [31:0] na, input logic st);
    logic inv, dec, cb, tk;
    logic [31:0] nc;
    opt = o; cr_idx = ix; link_req = lk; cr_word = cr; next_pc = na; strict = st;
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    inv = st & zbits(o);
    dec = !o[2];
    nc  = m_ctr - 32'd1;
    cb  = cr[31 - ix];                                      // R10
    tk  = !inv;
    if (!o[4] && (cb != o[3])) tk = 0;
    if (dec && ((nc == 0) != o[1])) tk = 0;
    chk("R12 valid", {31'd0, res_valid}, 32'd1);
    chk("R8 bad_form", {31'd0, bad_form}, {31'd0, inv});
    chk(inv ? "R11 taken" : tag_of(o), {31'd0, res_taken}, {31'd0, tk});
    chk("R1 target", res_target, {m_lnk[31:2], 2'b00});
    if (!inv) begin
      if (dec) m_ctr = nc;                                  // R13 wrap
      if (lk)  m_lnk = na;
    end
    chk(inv ? "R11 ctr" : "R13 ctr", ctr_value, m_ctr);
    chk(inv ? "R11 link" : "R2 link", link_value, m_lnk);
  endtask

  logic done = 0;
  initial begin
    #1_500_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();
    // reset state
    chk("R12 reset valid", {31'd0, res_valid}, 32'd0);
    chk("R13 reset ctr", ctr_value, CI);
    chk("R2 reset link", link_value, LI);
    // R6 count to zero: 3 -> 2, 1, 0; only last taken
    op(5'b10010, 0, 0, 0, 0, 1);
    op(5'b10010, 0, 0, 0, 0, 1);
    op(5'b10010, 0, 0, 0, 0, 1);
    chk("R6 zero taken", {31'd0, res_taken}, 32'd1);
    // R13 wrap 0 -> FFFFFFFF, non-zero test taken
    op(5'b10000, 0, 0, 0, 0, 1);
    chk("R13 wrap", ctr_value, 32'hFFFF_FFFF);
    // R1 link and branch in same op uses old link
    op(5'b10100, 0, 1, 0, 32'h0000_2004, 1);
    chk("R1 old link target", res_target, LI);
    op(5'b10100, 0, 0, 0, 0, 1);
    chk("R1 new link target", res_target, 32'h0000_2004);
    // R10 index 0 is MSB
    op(5'b01100, 0, 0, 32'h8000_0000, 0, 1);
    chk("R10 msb", {31'd0, res_taken}, 32'd1);
    op(5'b01100, 31, 0, 32'h8000_0000, 0, 1);
    chk("R10 lsb", {31'd0, res_taken}, 32'd0);
    // R8 strict vs relaxed; R11 suppression
    op(5'b11000, 0, 1, 0, 32'h0000_3000, 1);
    chk("R11 strict invalid", {31'd0, bad_form}, 32'd1);
    op(5'b11000, 0, 1, 0, 32'h0000_3000, 0);
    chk("R8 relaxed ok", {31'd0, bad_form}, 32'd0);
    // R9 y bit has no effect
    do_reset();
    op(5'b00101, 3, 0, 32'h0, 0, 1);
    chk("R9 y hint", {31'd0, res_taken}, 32'd1);
    @(negedge clk);
    chk("R12 idle", {31'd0, res_valid}, 32'd0);
    // random phase
    for (int i = 0; i < 600; i++) begin
      if (i % 25 == 0) do_reset();
      op(5'($urandom), 5'($urandom), 1'($urandom),
         $urandom, {$urandom_range(0, 32'h3FFF_FFFF), 2'b00} ^ 32'($urandom_range(0, 1)),
         ($urandom_range(0, 3) != 0));
      if (($urandom & 7) == 0) begin
        @(negedge clk);
        chk("R12 gap", {31'd0, res_valid}, 32'd0);
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule